// File: doc/BRIEF.md
# Serial Display Command Transmitter

This block sends command transactions to a display panel over a serial link. One transaction carries a command byte, then an address of one to four bytes (only in the quad-lane mode), then a run of dummy bit periods, then a counted stream of parameter or pixel bytes. The block drives the serial clock, an active-low chip select, a data/command select pin and four data lines.

A host sets the configuration inputs and pulses `start`. The block copies the configuration, pulls exactly the requested number of bytes from a valid/ready byte stream, and stops the serial clock at its idle level whenever that stream runs dry. When the last bit has been sent it raises a sticky transfer-complete flag, which can be masked from the interrupt output and is cleared by a pulse.

There are three serial modes. The 3-wire mode has no data/command pin and sends a marker bit ahead of every byte instead. The 4-wire mode uses a separate data/command pin. The quad mode chooses one or four data lanes separately for the command, the address and the data.

Top module: `lcd_serial_tx`

## Requirements
- R1: `mode` 1 selects 3-wire, 2 selects 4-wire and 3 selects quad. A `start` with `mode` 0 is refused: `busy` stays low and `cs_n` stays high.
- R2: The phases always run in the order command, address, dummy, data. `cmd_skip`=1 leaves the command out. An address only occurs in quad mode. A transaction with no phases left still completes and raises the flag.
- R3: In 3-wire mode, every byte goes out on `sdo[0]` behind a leading marker bit, which is 0 for the command and 1 for data bytes. `dc` stays low.
- R4: In 4-wire and quad modes, `dc` is low during the command bits and high during every later bit.
- R5: Bytes are sent MSB first. A one-lane bit is on `sdo[0]` with `sdo[3:1]` low. A four-lane bit period carries a nibble on `sdo[3:0]`, high nibble first, with `sdo[3]` as its MSB.
- R6: `cmd_quad`, `addr_quad` and `data_quad` (1 = four lanes, 0 = one lane) take effect only in quad mode. In every other mode they are ignored.
- R7: `addr_len`=n sends n+1 address bytes, starting with `addr[7:0]` and going up from there.
- R8: `dummy_cyc`=k inserts k bit periods before the data, with all data lines low.
- R9: `clk_mode[1]` is CPOL and `clk_mode[0]` is CPHA. When no bit is being sent, `sclk` sits at CPOL. A bit lasts 2·HALF_CYC clocks. Data changes at the start of a bit and is sampled on the leading edge when CPHA=0 and on the trailing edge when CPHA=1.
- R10: Exactly `data_cnt` bytes are taken, each on a cycle with `in_valid` and `in_ready` both high. While no byte is offered, `sclk` holds still. `in_ready` is low outside a transaction.
- R11: `cs_n` is low from the accepted start until the end of the transaction. With `cs_keep`=1 it stays low after the end.
- R12: `tc_flag` rises as `busy` falls at the end of a transaction. `tc_clr`=1 clears it, and a set in the same cycle takes priority. `irq` = `tc_flag` & ~`tc_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transaction when idle |
| mode | input | 2 | Serial mode: 1 = 3-wire, 2 = 4-wire, 3 = quad |
| clk_mode | input | 2 | {CPOL, CPHA} |
| cmd_skip | input | 1 | Leaves out the command phase |
| cmd_quad | input | 1 | Four lanes for the command (quad mode only) |
| addr_quad | input | 1 | Four lanes for the address |
| data_quad | input | 1 | Four lanes for the data (quad mode only) |
| addr_len | input | 2 | Number of address bytes minus one |
| addr | input | 32 | Address word, low byte sent first |
| dummy_cyc | input | DUM_W | Number of dummy bit periods |
| cmd | input | 8 | Command byte |
| data_cnt | input | CNT_W | Number of data bytes |
| cs_keep | input | 1 | Keeps chip select low after the end |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block takes a stream byte |
| tc_clr | input | 1 | Clears the transfer-complete flag |
| tc_mask | input | 1 | Masks the flag from `irq` |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select |
| sdo | output | 4 | Data lanes |
| busy | output | 1 | Transaction in progress |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with HALF_CYC=2, so one bit takes four clocks and transactions of dozens of bits finish quickly. With HALF_CYC above 1, the counting variant of the bit timer is the one under test. DUM_W=4 lets the largest dummy count, 15, be exercised directly. CNT_W stays at 24 so that the counter widths match the full-size block, while byte counts are kept small.

// File: rtl/lst_pkg.sv
package lst_pkg;
   typedef enum logic [1:0] {
      WM_PAR  = 2'd0,
      WM_3W   = 2'd1,
      WM_4W   = 2'd2,
      WM_QUAD = 2'd3
   } wire_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_NEXT  = 2'd1,
      SQ_SHIFT = 2'd2
   } sq_state_e;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_ADDR  = 2'd1,
      PH_DUMMY = 2'd2,
      PH_DATA  = 2'd3
   } phase_e;

   typedef struct packed {
      wire_mode_e mode;
      logic       cpol;
      logic       cpha;
      logic       cmd_en;
      logic       cmd_q;
      logic       addr_q;
      logic       data_q;
      logic [1:0] addr_last;
      logic       cs_keep;
   } txn_cfg_t;
endpackage

// File: rtl/lst_bit_tick.sv
module lst_bit_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic second_half,
   output logic bit_end
);
   localparam int BIT_LEN = 2 * HALF;
   localparam int CW      = $clog2(BIT_LEN);

   initial assert (HALF >= 1) else $error("lst_bit_tick: HALF must be 1 or more");

   generate
      if (HALF == 1) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph <= 1'b0;
            else        ph <= run ? ~ph : 1'b0;
         end
         assign second_half = ph;
         assign bit_end     = run & ph;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!run)                       cnt <= '0;
            else if (cnt == CW'(BIT_LEN - 1))    cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign second_half = (cnt >= CW'(HALF));
         assign bit_end     = run && (cnt == CW'(BIT_LEN - 1));

         // R9: every bit starts from the beginning of its period
         a_r9_bit_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run) |-> (cnt == '0));
      end
   endgenerate
endmodule

// File: rtl/lst_lane_shift.sv
module lst_lane_shift #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic             quad,
   input  logic [8:0]       load_val,
   output logic [LANES-1:0] lanes
);
   localparam int SW = 9;

   initial assert (LANES == 4) else $error("lst_lane_shift: four lanes expected");

   logic [SW-1:0] sh;
   logic          q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
         q  <= 1'b0;
      end else if (load) begin
         sh <= load_val;
         q  <= quad;
      end else if (shift) begin
         sh <= q ? {sh[SW-5:0], 4'b0000} : {sh[SW-2:0], 1'b0};
      end
   end

   assign lanes = q ? sh[SW-1:SW-4] : {{(LANES-1){1'b0}}, sh[SW-1]};
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx
   import lst_pkg::*;
#(
   parameter int HALF_CYC = 2,
   parameter int CNT_W    = 24,
   parameter int DUM_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode,
   input  logic [1:0]       clk_mode,
   input  logic             cmd_skip,
   input  logic             cmd_quad,
   input  logic             addr_quad,
   input  logic             data_quad,
   input  logic [1:0]       addr_len,
   input  logic [31:0]      addr,
   input  logic [DUM_W-1:0] dummy_cyc,
   input  logic [7:0]       cmd,
   input  logic [CNT_W-1:0] data_cnt,
   input  logic             cs_keep,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             tc_clr,
   input  logic             tc_mask,
   output logic             sclk,
   output logic             cs_n,
   output logic             dc,
   output logic [3:0]       sdo,
   output logic             busy,
   output logic             tc_flag,
   output logic             irq
);
   localparam int SLOT_W = (DUM_W > 4) ? DUM_W : 4;

   initial assert (CNT_W >= 1 && DUM_W >= 1 && HALF_CYC >= 1)
      else $error("lcd_serial_tx: widths and HALF_CYC must be positive");

   txn_cfg_t          cfg;
   sq_state_e         st;
   phase_e            ph, nxt_ph;
   logic [7:0]        cmd_r;
   logic [31:0]       addr_r;
   logic [DUM_W-1:0]  dummy_r;
   logic [CNT_W-1:0]  rem;
   logic [2:0]        aidx;
   logic [SLOT_W-1:0] slots, ld_slots;
   logic              dummy_u;
   logic              ld, ld_quad, ld_dc, ld_dummy, take, finish;
   logic [8:0]        ld_val;
   logic              half, bend, shf;
   logic [3:0]        lane_out;
   logic              three, quad_m;
   logic [7:0]        aby;

   assign three  = (cfg.mode == WM_3W);
   assign quad_m = (cfg.mode == WM_QUAD);
   assign aby    = addr_r[{aidx[1:0], 3'b000} +: 8];

   function automatic logic [SLOT_W-1:0] unit_slots(input logic q, input logic t);
      return q ? SLOT_W'(2) : (t ? SLOT_W'(9) : SLOT_W'(8));
   endfunction

   // phase selection at each unit boundary
   always_comb begin
      ld       = 1'b0;
      ld_val   = '0;
      ld_quad  = 1'b0;
      ld_dc    = 1'b1;
      ld_dummy = 1'b0;
      ld_slots = '0;
      take     = 1'b0;
      finish   = 1'b0;
      nxt_ph   = ph;
      if (st == SQ_NEXT) begin
         unique case (ph)
            PH_CMD: begin
               nxt_ph = PH_ADDR;
               if (cfg.cmd_en) begin
                  ld       = 1'b1;
                  ld_dc    = 1'b0;
                  ld_quad  = quad_m & cfg.cmd_q;
                  ld_val   = three ? {1'b0, cmd_r} : {cmd_r, 1'b0};
                  ld_slots = unit_slots(ld_quad, three);
               end
            end
            PH_ADDR: begin
               if (quad_m && (aidx <= {1'b0, cfg.addr_last})) begin
                  ld       = 1'b1;
                  ld_quad  = cfg.addr_q;
                  ld_val   = {aby, 1'b0};
                  ld_slots = unit_slots(ld_quad, 1'b0);
               end else begin
                  nxt_ph = PH_DUMMY;
               end
            end
            PH_DUMMY: begin
               nxt_ph = PH_DATA;
               if (dummy_r != '0) begin
                  ld       = 1'b1;
                  ld_dummy = 1'b1;
                  ld_slots = SLOT_W'(dummy_r);
               end
            end
            PH_DATA: begin
               if (rem == '0) begin
                  finish = 1'b1;
               end else if (in_valid) begin
                  ld       = 1'b1;
                  take     = 1'b1;
                  ld_quad  = quad_m & cfg.data_q;
                  ld_val   = three ? {1'b1, in_data} : {in_data, 1'b0};
                  ld_slots = unit_slots(ld_quad, three);
               end
            end
            default: ;
         endcase
      end
   end

   assign in_ready = (st == SQ_NEXT) && (ph == PH_DATA) && (rem != '0);
   assign busy     = (st != SQ_IDLE);
   assign shf      = (st == SQ_SHIFT) && bend && (slots != SLOT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         ph      <= PH_CMD;
         cfg     <= '0;
         cmd_r   <= '0;
         addr_r  <= '0;
         dummy_r <= '0;
         rem     <= '0;
         aidx    <= '0;
         slots   <= '0;
         dummy_u <= 1'b0;
         cs_n    <= 1'b1;
         dc      <= 1'b0;
         tc_flag <= 1'b0;
      end else begin
         if (tc_clr) tc_flag <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start && (mode != WM_PAR)) begin
                  cfg.mode      <= wire_mode_e'(mode);
                  cfg.cpol      <= clk_mode[1];
                  cfg.cpha      <= clk_mode[0];
                  cfg.cmd_en    <= ~cmd_skip;
                  cfg.cmd_q     <= cmd_quad;
                  cfg.addr_q    <= addr_quad;
                  cfg.data_q    <= data_quad;
                  cfg.addr_last <= addr_len;
                  cfg.cs_keep   <= cs_keep;
                  cmd_r         <= cmd;
                  addr_r        <= addr;
                  dummy_r       <= dummy_cyc;
                  rem           <= data_cnt;
                  aidx          <= '0;
                  ph            <= PH_CMD;
                  st            <= SQ_NEXT;
                  cs_n          <= 1'b0;
               end
            end
            SQ_NEXT: begin
               ph <= nxt_ph;
               if (ld) begin
                  st      <= SQ_SHIFT;
                  slots   <= ld_slots;
                  dummy_u <= ld_dummy;
                  dc      <= three ? 1'b0 : ld_dc;
               end
               if (ld && (ph == PH_ADDR)) aidx <= aidx + 1'b1;
               if (take) rem <= rem - 1'b1;
               if (finish) begin
                  st      <= SQ_IDLE;
                  cs_n    <= ~cfg.cs_keep;
                  dc      <= 1'b0;
                  tc_flag <= 1'b1;
               end
            end
            SQ_SHIFT: begin
               if (bend) begin
                  slots <= slots - 1'b1;
                  if (slots == SLOT_W'(1)) st <= SQ_NEXT;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   lst_bit_tick #(.HALF(HALF_CYC)) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (st == SQ_SHIFT),
      .second_half (half),
      .bit_end     (bend)
   );

   lst_lane_shift #(.LANES(4)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .shift    (shf),
      .quad     (ld_quad),
      .load_val (ld_val),
      .lanes    (lane_out)
   );

   assign sdo = (st == SQ_SHIFT) ? lane_out : 4'b0000;

   always_comb begin
      if (st == SQ_SHIFT)  sclk = cfg.cpol ^ (cfg.cpha ? ~half : half);
      else if (busy)       sclk = cfg.cpol;
      else                 sclk = clk_mode[1];
   end

   assign irq = tc_flag & ~tc_mask;

   a_r11_cs_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);

   a_r10_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   a_r12_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag) |-> ($past(busy) && !busy));

   a_r1_reject_parallel: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (mode == 2'd0)) |=> !busy);

   a_r8_dummy_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_SHIFT) && dummy_u) |-> (sdo == 4'b0000));
endmodule

// File: tb/test_lcd_serial_tx.sv
`timescale 1ns/1ps
module test_lcd_serial_tx;
   localparam int HALF  = 2;
   localparam int CNT_W = 24;
   localparam int DUM_W = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       mode = 2'd2;
   logic [1:0]       clk_mode = 2'd0;
   logic             cmd_skip = 1'b0, cmd_quad = 1'b0, addr_quad = 1'b0, data_quad = 1'b0;
   logic [1:0]       addr_len = 2'd0;
   logic [31:0]      addr = '0;
   logic [DUM_W-1:0] dummy_cyc = '0;
   logic [7:0]       cmd = '0;
   logic [CNT_W-1:0] data_cnt = '0;
   logic             cs_keep = 1'b0;
   logic [7:0]       in_data = '0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic             tc_clr = 1'b0, tc_mask = 1'b0;
   logic             sclk, cs_n, dc, busy, tc_flag, irq;
   logic [3:0]       sdo;

   lcd_serial_tx #(.HALF_CYC(HALF), .CNT_W(CNT_W), .DUM_W(DUM_W)) i_lcd_serial_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .clk_mode(clk_mode),
      .cmd_skip(cmd_skip), .cmd_quad(cmd_quad), .addr_quad(addr_quad), .data_quad(data_quad),
      .addr_len(addr_len), .addr(addr), .dummy_cyc(dummy_cyc), .cmd(cmd), .data_cnt(data_cnt),
      .cs_keep(cs_keep), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .tc_clr(tc_clr), .tc_mask(tc_mask), .sclk(sclk), .cs_n(cs_n), .dc(dc), .sdo(sdo),
      .busy(busy), .tc_flag(tc_flag), .irq(irq));

   int n_chk = 0;
   int n_fail = 0;
   int valid_pct = 75;
   logic [7:0] dbuf [16];
   logic [4:0] exp_q [$];
   logic [4:0] cap_q [$];
   logic cap_pol = 1'b0, cap_pha = 1'b0;
   logic prev_sclk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // receiver model: capture {dc, sdo} on the sampling edge
   always @(negedge clk) begin
      if (!cs_n && (prev_sclk !== sclk) && (sclk === (cap_pol ^ ~cap_pha)))
         cap_q.push_back({dc, sdo});
      prev_sclk = sclk;
   end

   task automatic push_byte(input logic [7:0] b, input bit q, input bit three,
                            input bit mark, input bit pin);
      if (q) begin
         exp_q.push_back({pin, b[7:4]});
         exp_q.push_back({pin, b[3:0]});
      end else begin
         if (three) exp_q.push_back({4'b0000, mark});
         for (int i = 7; i >= 0; i--) exp_q.push_back({pin, 3'b000, b[i]});
      end
   endtask

   task automatic run_txn(input logic [1:0] md, input logic [1:0] cm, input bit skip,
                          input bit cq, input bit aq, input bit dq, input logic [1:0] al,
                          input logic [31:0] av, input int dum, input logic [7:0] c,
                          input int n, input bit keep, input string tag);
      bit three, qm, pin;
      int k, mism, first;
      bit pend;
      three = (md == 2'd1);
      qm    = (md == 2'd3);
      pin   = !three;
      exp_q.delete();
      if (!skip) push_byte(c, qm & cq, three, 1'b0, 1'b0);
      if (qm) for (int i = 0; i <= int'(al); i++) push_byte(av[8*i +: 8], aq, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < dum; i++) exp_q.push_back({pin, 4'b0000});
      for (int i = 0; i < n; i++) push_byte(dbuf[i], qm & dq, three, 1'b1, pin);

      @(negedge clk);
      mode = md; clk_mode = cm; cmd_skip = skip; cmd_quad = cq; addr_quad = aq;
      data_quad = dq; addr_len = al; addr = av; dummy_cyc = DUM_W'(dum); cmd = c;
      data_cnt = CNT_W'(n); cs_keep = keep; cap_pol = cm[1]; cap_pha = cm[0];
      tc_clr = 1'b1;
      @(negedge clk);
      tc_clr = 1'b0;
      cap_q.delete();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0; pend = 1'b0;
      while (k < n) begin
         if (pend) k++;
         if (k < n) begin
            in_data  = dbuf[k];
            in_valid = (($urandom % 100) < valid_pct);
         end else begin
            in_valid = 1'b0;
         end
         pend = in_valid && in_ready;
         if (k < n) @(negedge clk);
      end
      in_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      mism = 0; first = -1;
      for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
         if (cap_q[i] !== exp_q[i]) begin
            mism++;
            if (first < 0) first = i;
         end
      check(cap_q.size() == exp_q.size(), tag, "bit period count", cap_q.size(), exp_q.size());
      if (first >= 0)
         check(1'b0, tag, "bit stream {dc,sdo}", cap_q[first], exp_q[first]);
      else
         check(1'b1, tag, "bit stream {dc,sdo}", 0, 0);
      check(tc_flag === 1'b1, "R12", "flag after end", tc_flag, 1);
      check(cs_n === !keep, "R11", "cs_n after end", cs_n, !keep);
      check(in_ready === 1'b0, "R10", "ready after end", in_ready, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(cs_n === 1'b1, "R11", "reset cs_n", cs_n, 1);
      check(busy === 1'b0 && tc_flag === 1'b0, "R12", "reset busy/flag", {busy, tc_flag}, 0);
      check(irq === 1'b0, "R12", "reset irq", irq, 0);
      check(sclk === 1'b0, "R9", "idle sclk CPOL=0", sclk, 0);
      clk_mode = 2'b10;
      @(negedge clk);
      check(sclk === 1'b1, "R9", "idle sclk CPOL=1", sclk, 1);

      // R1: parallel mode refused
      cap_q.delete();
      mode = 2'd0; cap_pol = 1'b1; cap_pha = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      check(busy === 1'b0, "R1", "mode 0 busy", busy, 0);
      check(cs_n === 1'b1, "R1", "mode 0 cs_n", cs_n, 1);
      check(cap_q.size() == 0, "R1", "mode 0 activity", cap_q.size(), 0);

      // R5: bit order, one and four lanes
      dbuf[0] = 8'h81; dbuf[1] = 8'h3C;
      run_txn(2'd2, 2'd0, 0, 0, 0, 0, 2'd0, 0, 0, 8'hA5, 2, 0, "R5");
      run_txn(2'd3, 2'd0, 0, 1, 0, 1, 2'd0, 32'h5A, 0, 8'hC3, 2, 0, "R5");
      // R3: 3-wire marker bit
      run_txn(2'd1, 2'd0, 0, 0, 0, 0, 2'd0, 0, 0, 8'h2A, 2, 0, "R3");
      // R4: 4-wire dc pin
      run_txn(2'd2, 2'd1, 0, 0, 0, 0, 2'd0, 0, 1, 8'hF0, 1, 0, "R4");
      // R7: four address bytes, low byte first
      run_txn(2'd3, 2'd0, 0, 0, 1, 1, 2'd3, 32'h44332211, 0, 8'h02, 2, 0, "R7");
      run_txn(2'd3, 2'd3, 0, 0, 0, 0, 2'd1, 32'hBEEF, 0, 8'h32, 1, 0, "R7");
      // R8: largest dummy count
      run_txn(2'd2, 2'd0, 0, 0, 0, 0, 2'd0, 0, 15, 8'h11, 1, 0, "R8");
      // R6: lane selects ignored outside quad mode
      run_txn(2'd2, 2'd0, 0, 1, 1, 1, 2'd2, 32'h12345678, 0, 8'h96, 2, 0, "R6");
      run_txn(2'd1, 2'd2, 0, 1, 1, 1, 2'd2, 32'h12345678, 0, 8'h69, 1, 0, "R6");
      // R2: masked command, empty transaction
      run_txn(2'd3, 2'd0, 1, 0, 1, 0, 2'd0, 32'h77, 2, 8'hFF, 1, 0, "R2");
      run_txn(2'd2, 2'd0, 1, 0, 0, 0, 2'd0, 0, 0, 8'hFF, 0, 0, "R2");
      // R9: all clock modes
      for (int m = 0; m < 4; m++)
         run_txn(2'd2, 2'(m), 0, 0, 0, 0, 2'd0, 0, 1, 8'h5B, 1, 0, "R9");
      // R10: starved stream
      valid_pct = 10;
      for (int i = 0; i < 5; i++) dbuf[i] = 8'(i * 37 + 5);
      run_txn(2'd3, 2'd1, 0, 1, 1, 0, 2'd0, 32'h9, 0, 8'h4E, 5, 0, "R10");
      valid_pct = 75;
      // R11: chip select held across transactions
      run_txn(2'd2, 2'd0, 0, 0, 0, 0, 2'd0, 0, 0, 8'h2C, 1, 1, "R11");
      repeat (5) @(negedge clk);
      check(cs_n === 1'b0, "R11", "cs_n held while idle", cs_n, 0);
      run_txn(2'd2, 2'd0, 0, 0, 0, 0, 2'd0, 0, 0, 8'h2D, 1, 0, "R11");

      // R12: mask and clear
      tc_mask = 1'b1;
      @(negedge clk);
      check(irq === 1'b0, "R12", "irq masked", irq, 0);
      tc_mask = 1'b0;
      @(negedge clk);
      check(irq === 1'b1, "R12", "irq unmasked", irq, 1);
      tc_clr = 1'b1;
      @(negedge clk);
      tc_clr = 1'b0;
      @(negedge clk);
      check(tc_flag === 1'b0 && irq === 1'b0, "R12", "flag cleared", {tc_flag, irq}, 0);

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [1:0] md;
         int n;
         md = 2'(1 + ($urandom % 3));
         n  = $urandom % 6;
         for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
         run_txn(md, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), $urandom, $urandom % 4, 8'($urandom), n, 0,
                 (md == 2'd1) ? "R3" : ((md == 2'd2) ? "R4" : "R6"));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule